// File: doc/BRIEF.md
# Register-Direct Integer Execute Unit

This block executes two-operand 32-bit integer instructions whose operands are both registers. Each instruction arrives as an opcode byte and an operand-selector byte over a valid/ready handshake. The block holds eight 32-bit general registers and three status flags: sign, zero and overflow. It decodes the selector byte into a source index and a destination index and reads both registers. It then computes the result and, in the same clock edge that accepts the instruction, writes one register, or two for an exchange.

The supported operations are add, subtract, AND, OR, XOR, complement, compare, copy and exchange. Every opcode has its own rule for whether it writes back and which flags it changes. An opcode outside the set, or any addressing mode other than register direct, changes nothing and raises a one-cycle error pulse. A combinational debug read port exposes any register, so the register file can be observed without extra instructions.

Top module: `ixu_core`

## Requirements
- R1: While reset is asserted, all eight registers read zero, the three flags are low, the error output is low and ready is low. Ready goes high on the first clock edge after reset is released and stays high.
- R2: The selector byte is split as mode = bits 7:6, source index = bits 5:3 and destination index = bits 2:0. Only mode 3 is executed.
- R3: Add (0x01) writes dst+src to dst, and subtract (0x29) writes dst-src to dst. Both set the sign flag from result bit 31 and set the zero flag when the result is zero. Both set the overflow flag on signed two's-complement overflow.
- R4: AND (0x21), OR (0x09) and XOR (0x31) write dst op src to dst, set the sign and zero flags from the result, and clear the overflow flag.
- R5: Complement (0xF7) ignores the source field and writes ~dst to dst. It sets the sign and zero flags from the result and clears the overflow flag.
- R6: Compare (0x39) writes no register. It sets the sign, zero and overflow flags exactly as subtract would for dst-src.
- R7: Copy (0x89) writes src to dst and leaves all flags unchanged.
- R8: Exchange (0x87) writes the old src to dst and the old dst to src in one instruction, and leaves the flags unchanged. When both indices are equal, the register keeps its value.
- R9: An instruction whose mode field is not 3 changes no register and no flag. The error output is high for exactly the one cycle after its acceptance.
- R10: An opcode not listed in R3 to R8 changes no register and no flag. The error output is high for exactly the one cycle after its acceptance.
- R11: Results and flags of an accepted instruction are visible from the clock edge that accepts it. Back-to-back instructions on consecutive cycles each see the results of the previous one.
- R12: The debug port returns the register selected by the debug index combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_sel | input | 8 | Operand-selector byte |
| dbg_idx | input | 3 | Debug register index |
| dbg_value | output | 32 | Debug register value |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Overflow flag |
| err_bad_instr | output | 1 | One-cycle pulse for an illegal instruction |

## Verification
A wrong decode, a wrong flag rule or a bad write enable shows up at the debug port or the flag outputs at the next falling edge after the instruction. Every register is read back after every instruction, so a corrupted register is caught one cycle after it is written, even if no later instruction reads it. The bench sweeps every opcode value, every selector value and every source/destination pair for each operation over values chosen to cause overflow. Because register contents are carried from one instruction to the next, an error in any earlier instruction also shows in the later ones.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  parameter int unsigned XLEN  = 32;
  parameter int unsigned NREGS = 8;
  localparam int unsigned IDXW = $clog2(NREGS);

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOT, K_CMP, K_MOV, K_XCHG, K_BAD
  } op_kind_e;

  typedef struct packed {
    op_kind_e        kind;
    logic [IDXW-1:0] src;
    logic [IDXW-1:0] dst;
  } dec_t;

  typedef struct packed {
    logic sgn;
    logic zro;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/ixu_decode.sv
module ixu_decode
  import ixu_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] sel,
  output dec_t       dec
);
  op_kind_e kind;

  always_comb begin
    unique case (opcode)
      8'h01:   kind = K_ADD;
      8'h29:   kind = K_SUB;
      8'h21:   kind = K_AND;
      8'h09:   kind = K_OR;
      8'h31:   kind = K_XOR;
      8'hF7:   kind = K_NOT;
      8'h39:   kind = K_CMP;
      8'h89:   kind = K_MOV;
      8'h87:   kind = K_XCHG;
      default: kind = K_BAD;
    endcase
  end

  // Mode field in bits 7:6; only register-direct (3) is executed
  always_comb begin
    dec.kind = (sel[7:6] == 2'b11) ? kind : K_BAD;
    dec.src  = sel[5:3];
    dec.dst  = sel[2:0];
  end
endmodule

// File: rtl/ixu_alu.sv
module ixu_alu
  import ixu_pkg::*;
(
  input  op_kind_e         kind,
  input  logic [XLEN-1:0]  a,      // destination operand
  input  logic [XLEN-1:0]  b,      // source operand
  input  flags_t           fl_in,
  output logic [XLEN-1:0]  result,
  output logic             wr_dst,
  output logic             wr_src,
  output flags_t           fl_out
);
  logic [XLEN-1:0] sum, diff;
  logic            sum_ov, diff_ov;

  assign sum     = a + b;
  assign diff    = a - b;
  assign sum_ov  = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1]  != a[XLEN-1]);
  assign diff_ov = (a[XLEN-1] != b[XLEN-1]) && (diff[XLEN-1] != a[XLEN-1]);

  always_comb begin
    result = '0;
    wr_dst = 1'b0;
    wr_src = 1'b0;
    fl_out = fl_in;
    unique case (kind)
      K_ADD:  begin result = sum;   wr_dst = 1'b1; fl_out.ovf = sum_ov;  end
      K_SUB:  begin result = diff;  wr_dst = 1'b1; fl_out.ovf = diff_ov; end
      K_CMP:  begin result = diff;                 fl_out.ovf = diff_ov; end
      K_AND:  begin result = a & b; wr_dst = 1'b1; fl_out.ovf = 1'b0;    end
      K_OR:   begin result = a | b; wr_dst = 1'b1; fl_out.ovf = 1'b0;    end
      K_XOR:  begin result = a ^ b; wr_dst = 1'b1; fl_out.ovf = 1'b0;    end
      K_NOT:  begin result = ~a;    wr_dst = 1'b1; fl_out.ovf = 1'b0;    end
      K_MOV:  begin result = b;     wr_dst = 1'b1;                       end
      K_XCHG: begin result = b;     wr_dst = 1'b1; wr_src = 1'b1;        end
      default: ;
    endcase
    if (kind inside {K_ADD, K_SUB, K_CMP, K_AND, K_OR, K_XOR, K_NOT}) begin
      fl_out.sgn = result[XLEN-1];
      fl_out.zro = (result == '0);
    end
  end
endmodule

// File: rtl/ixu_regfile.sv
module ixu_regfile
  import ixu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  rd_a_idx,
  output logic [XLEN-1:0]  rd_a,
  input  logic [IDXW-1:0]  rd_b_idx,
  output logic [XLEN-1:0]  rd_b,
  input  logic [IDXW-1:0]  rd_d_idx,
  output logic [XLEN-1:0]  rd_d,
  input  logic             we_a,
  input  logic [IDXW-1:0]  wa_idx,
  input  logic [XLEN-1:0]  wa_data,
  input  logic             we_b,
  input  logic [IDXW-1:0]  wb_idx,
  input  logic [XLEN-1:0]  wb_data
);
  logic [XLEN-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic            en;
    logic [XLEN-1:0] nxt;
    always_comb begin
      en  = 1'b0;
      nxt = regs[g];
      if (we_b && wb_idx == IDXW'(g)) begin en = 1'b1; nxt = wb_data; end
      if (we_a && wa_idx == IDXW'(g)) begin en = 1'b1; nxt = wa_data; end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= nxt;
    end
  end

  assign rd_a = regs[rd_a_idx];
  assign rd_b = regs[rd_b_idx];
  assign rd_d = regs[rd_d_idx];

  // R8
  xchg_same_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b && wa_idx == wb_idx) |-> (wa_data == wb_data));
endmodule

// File: rtl/ixu_core.sv
module ixu_core
  import ixu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_sel,
  input  logic [IDXW-1:0]  dbg_idx,
  output logic [XLEN-1:0]  dbg_value,
  output logic             flag_sign,
  output logic             flag_zero,
  output logic             flag_ovf,
  output logic             err_bad_instr
);
  dec_t            dec;
  logic [XLEN-1:0] dst_val, src_val, alu_res;
  logic            alu_wd, alu_ws, accept;
  flags_t          flags_q, flags_d, alu_fl;
  logic            ready_q, err_q, err_d;

  assign accept = in_valid && ready_q;

  ixu_decode u_dec (.opcode(in_opcode), .sel(in_sel), .dec(dec));

  ixu_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(dec.dst), .rd_a(dst_val),
    .rd_b_idx(dec.src), .rd_b(src_val),
    .rd_d_idx(dbg_idx), .rd_d(dbg_value),
    .we_a(accept && alu_wd), .wa_idx(dec.dst), .wa_data(alu_res),
    .we_b(accept && alu_ws), .wb_idx(dec.src), .wb_data(dst_val));

  ixu_alu u_alu (
    .kind(dec.kind), .a(dst_val), .b(src_val), .fl_in(flags_q),
    .result(alu_res), .wr_dst(alu_wd), .wr_src(alu_ws), .fl_out(alu_fl));

  always_comb begin
    flags_d = accept ? alu_fl : flags_q;
    err_d   = accept && (dec.kind == K_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      err_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      err_q   <= err_d;
      ready_q <= 1'b1;
    end
  end

  assign in_ready      = ready_q;
  assign flag_sign     = flags_q.sgn;
  assign flag_zero     = flags_q.zro;
  assign flag_ovf      = flags_q.ovf;
  assign err_bad_instr = err_q;

  // R9 R10
  bad_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(flags_q));
  // R7
  copy_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_opcode == 8'h89 && in_sel[7:6] == 2'b11) |=> $stable(flags_q));
  // R5
  not_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_opcode == 8'hF7 && in_sel[7:6] == 2'b11) |=> !flags_q.ovf);
  // R4
  logic_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_opcode inside {8'h21, 8'h09, 8'h31} && in_sel[7:6] == 2'b11)
      |=> !flags_q.ovf);
  // R11
  ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  // R9
  err_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(in_valid));
endmodule

// File: tb/test_ixu_core.sv
module test_ixu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_opcode, in_sel;
  logic [2:0]  dbg_idx;
  logic [31:0] dbg_value;
  logic        flag_sign, flag_zero, flag_ovf, err_bad_instr;

  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  logic [31:0] mreg [8];
  logic        msf, mzf, mof;

  always #4 clk = ~clk;

  ixu_core i_ixu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_sel(in_sel), .dbg_idx(dbg_idx),
    .dbg_value(dbg_value), .flag_sign(flag_sign), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf), .err_bad_instr(err_bad_instr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_err);
    chk(req, {31'd0, err_bad_instr}, {31'd0, exp_err});
    chk(req, {29'd0, flag_sign, flag_zero, flag_ovf}, {29'd0, msf, mzf, mof});
    for (int r = 0; r < 8; r++) begin
      dbg_idx = 3'(r);
      #1;
      chk(req, dbg_value, mreg[r]);  // R12 debug read
    end
  endtask

  // Issue one instruction; predicted state comes from the requirements
  task automatic exec(input logic [7:0] op, input logic [7:0] sel, input string req);
    logic [2:0]  s, d;
    logic [31:0] a, b, res;
    logic        bad;
    s   = sel[5:3];
    d   = sel[2:0];
    a   = mreg[d];
    b   = mreg[s];
    bad = (sel[7:6] != 2'b11) ||
          !(op inside {8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'hF7, 8'h39, 8'h89, 8'h87});
    if (!bad) begin
      case (op)
        8'h01: begin res = a + b; mreg[d] = res;
          mof = (a[31] == b[31]) && (res[31] != a[31]); end
        8'h29, 8'h39: begin res = a - b; if (op == 8'h29) mreg[d] = res;
          mof = (a[31] != b[31]) && (res[31] != a[31]); end
        8'h21: begin res = a & b; mreg[d] = res; mof = 1'b0; end
        8'h09: begin res = a | b; mreg[d] = res; mof = 1'b0; end
        8'h31: begin res = a ^ b; mreg[d] = res; mof = 1'b0; end
        8'hF7: begin res = ~a;    mreg[d] = res; mof = 1'b0; end
        8'h89: begin res = b; mreg[d] = b; end
        default: begin res = b; mreg[s] = a; mreg[d] = b; end
      endcase
      if (!(op inside {8'h89, 8'h87})) begin
        msf = res[31];
        mzf = (res == 32'd0);
      end
    end
    @(negedge clk);
    in_valid  = 1'b1;
    in_opcode = op;
    in_sel    = sel;
    @(negedge clk);
    in_valid  = 1'b0;
    check_all(req, bad);
  endtask

  // Build a constant: r7 holds 1, target doubled and incremented bit by bit
  task automatic set_one;
    exec(8'h31, 8'hFF, "R4");  // r7 = 0
    exec(8'hF7, 8'hC7, "R5");  // r7 = -1
    exec(8'h31, 8'hF6, "R4");  // r6 = 0
    exec(8'h29, 8'hFE, "R3");  // r6 = 0 - (-1) = 1
    exec(8'h89, 8'hF7, "R7");  // r7 = r6
  endtask

  task automatic load(input logic [2:0] t, input logic [31:0] v);
    exec(8'h31, {2'b11, t, t}, "R4");
    for (int i = 31; i >= 0; i--) begin
      exec(8'h01, {2'b11, t, t}, "R3");
      if (v[i]) exec(8'h01, {2'b11, 3'd7, t}, "R3");
    end
  endtask

  function automatic logic [31:0] pattern(input int set, input int idx);
    case (set)
      0: return 32'h0000_0010 * (idx + 1) + 32'(idx);
      1: case (idx)
           0: return 32'h7FFF_FFFF;  1: return 32'h8000_0000;
           2: return 32'h0000_0001;  3: return 32'hFFFF_FFFF;
           4: return 32'h0000_0000;  default: return 32'h8000_0001;
         endcase
      default: return 32'hA5A5_0F0F ^ (32'h1357_9BDF * 32'(idx + 3));
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [9];
    ops = '{8'h01, 8'h29, 8'h21, 8'h09, 8'h31, 8'hF7, 8'h39, 8'h89, 8'h87};
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_sel = '0; dbg_idx = '0;
    for (int r = 0; r < 8; r++) mreg[r] = '0;
    msf = 0; mzf = 0; mof = 0;
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0);
    chk("R1", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {31'd0, in_ready}, 32'd1);

    // Worked cases: OR and compare with r0/r3 (selector 0xD8: src 3, dst 0)
    set_one();
    load(3'd0, 32'h0a0b0c0d); load(3'd3, 32'ha0b0c0d0);
    exec(8'h09, 8'hD8, "R4");
    dbg_idx = 3'd0; #1; chk("R4", dbg_value, 32'haabbccdd);
    load(3'd0, 32'h0a0b0c07); load(3'd3, 32'h0a0b0c0d);
    exec(8'h39, 8'hD8, "R6");
    chk("R6", {29'd0, flag_sign, flag_zero, flag_ovf}, 32'b100);
    load(3'd0, 32'h0a0b0c0d);
    exec(8'h39, 8'hD8, "R6");
    chk("R6", {31'd0, flag_zero}, 32'd1);
    exec(8'h87, 8'hDB, "R8");  // exchange r3 with itself

    // Sweep every opcode value in register-direct mode (R10 for unlisted)
    for (int op = 0; op < 256; op++) exec(8'(op), 8'hC1, "R10");
    // Sweep every selector value with add (R9 for modes 0..2, R2 decode)
    set_one();
    for (int s = 0; s < 256; s++) exec(8'h01, 8'(s), "R9");

    // Each operation over every src/dst pair and three value sets
    for (int set = 0; set < 3; set++) begin
      for (int k = 0; k < 9; k++) begin
        set_one();
        for (int r = 0; r < 6; r++) load(3'(r), pattern(set, r));
        for (int s = 0; s < 64; s++) exec(ops[k], {2'b11, 6'(s)}, "R2");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule